// File: doc/BRIEF.md
# Scanning Multiplexed-ADC Host Controller

This block runs a serial multiplexed converter through a list of input selections. Each list entry names a channel and whether it is read on its own against ground (or against the shared common input) or as one side of a differential pair. For each accepted entry the controller forms the converter's 7-bit setup word. It then waits out an acquisition window, holds the convert strobe high for the worst-case conversion time, and drops the strobe to run a 16-clock serial frame. The frame sends the new setup word and receives the result of the conversion that has just finished.

The converter applies a setup word only at the next conversion, so the data read in a frame belongs to the entry sent in the frame before it. The controller therefore carries each entry's tag forward one frame. It also adds one extra frame after the last entry to pull out the final result. Results leave on a valid/ready stream that carries a channel tag. The first result of every scan is flagged as stale. While the stream is stalled, the scan holds and no new conversion starts.

The serial clock comes from the system clock through a divider whose half period is set at a port. The scan list and the mode inputs must stay stable while a scan runs.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, and while no scan runs, cs_conv, sck, sdi and res_valid are all low.
- R2: A list entry is 4 bits, with bit 3 = differential and bits 2:0 = channel; entry i sits at scan_list[4i+3:4i]. For a single-ended entry the setup word is sent MSB first on sdi over the first 7 rising sck edges, in this order: 1, chan[0], chan[2], chan[1], use_com, unipolar, 0. The remaining 9 bits of the frame are 0.
- R3: For a differential entry the setup word is 0, chan[0], chan[2], chan[1], 0, unipolar, 0. The named channel is the positive side, so an odd channel sets the second bit, and the common bit is always 0.
- R4: cs_conv stays high for at least CONV_CYC clocks before it falls, and sck and sdi are both low throughout that time.
- R5: At least ACQ_CYC clocks pass between the last falling sck edge of a frame and the next rise of cs_conv.
- R6: Each frame has exactly 16 sck pulses. Each pulse is high for sck_half clocks and low for sck_half clocks. sdo is sampled on the rising edges, MSB first, into res_data.
- R7: Each result carries in res_chan and res_diff the entry sent in the previous frame. The first result of a scan has res_stale = 1 and a zero tag.
- R8: A single-ended entry on channel 7 while use_com = 1 is skipped: no frame is sent for it and no result is tagged with it.
- R9: While res_valid is high and res_ready is low, res_valid, res_data and the tag hold steady and cs_conv stays low.
- R10: A scan with k accepted entries posts exactly k+1 results and then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a scan when idle |
| scan_list | input | 4*ENTRIES | Packed scan entries |
| scan_len | input | clog2(ENTRIES+1) | Number of entries to scan |
| use_com | input | 1 | Single-ended entries use channel 7 as common negative |
| unipolar | input | 1 | Unipolar conversion select |
| sck_half | input | DIVW | Serial clock half period in system clocks |
| sdo | input | 1 | Serial data from converter |
| sck | output | 1 | Serial clock to converter |
| sdi | output | 1 | Serial data to converter |
| cs_conv | output | 1 | Convert strobe and frame select |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts result |
| res_data | output | RES_W | Converted result |
| res_chan | output | 3 | Channel tag of the result |
| res_diff | output | 1 | Differential tag of the result |
| res_stale | output | 1 | Result predates this scan's settings |

## Verification
The hardest case to reach is a skipped entry sitting between accepted entries while the output stream is stalled. Here the one-frame tag delay has to pass over the gap and must not stretch or shift the stream. The directed scan reaches this with a channel-7 single-ended entry placed second under common mode, and with res_ready held low from the start. This stalls the stale first result for many cycles before the tagged results drain. A bench model of the converter latches each received setup word at the convert strobe and returns it inside the next frame's data, so every tag and encoding can be checked against the entry list.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int ENTRIES  = 8,
  parameter int CONV_CYC = 438,
  parameter int ACQ_CYC  = 188,
  parameter int DIVW     = 4,
  parameter int RES_W    = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  input  logic [4*ENTRIES-1:0]           scan_list,
  input  logic [$clog2(ENTRIES+1)-1:0]   scan_len,
  input  logic                           use_com,
  input  logic                           unipolar,
  input  logic [DIVW-1:0]                sck_half,
  input  logic                           sdo,
  output logic                           sck,
  output logic                           sdi,
  output logic                           cs_conv,
  output logic                           res_valid,
  input  logic                           res_ready,
  output logic [RES_W-1:0]               res_data,
  output logic [2:0]                     res_chan,
  output logic                           res_diff,
  output logic                           res_stale
);
  localparam int LW    = $clog2(ENTRIES+1);
  localparam int CW    = $clog2((CONV_CYC > ACQ_CYC ? CONV_CYC : ACQ_CYC) + 1);
  localparam int BW    = $clog2(RES_W);
  localparam int CFG_W = 7;
  localparam logic [CW-1:0] CONV_LAST = CW'(CONV_CYC - 1);
  localparam logic [CW-1:0] ACQ_LAST  = CW'(ACQ_CYC - 1);

  typedef enum logic [2:0] {IDLE, PICK, ACQ, CONV, XFER, POST} st_t;
  st_t st;

  logic [LW-1:0]        ptr;
  logic [CW-1:0]        cnt;
  logic [DIVW-1:0]      hc;
  logic [BW-1:0]        bits;
  logic [CFG_W-1:0]     cfg;
  logic [3:0]           cur_tag, prev_tag;
  logic                 first, flush;
  logic [RES_W-1:0]     shout, rx;
  logic [4*ENTRIES-1:0] lst_sh;
  logic [3:0]           ent;
  logic                 bad, hc_done, list_end;

  assign lst_sh   = scan_list >> {ptr, 2'b00};
  assign ent      = lst_sh[3:0];
  assign bad      = use_com && !ent[3] && (ent[2:0] == 3'd7);
  assign list_end = (ptr >= scan_len) || (ptr >= LW'(ENTRIES));
  assign hc_done  = ({1'b0, hc} + 1'b1) >= {1'b0, sck_half};
  assign sdi      = shout[RES_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= IDLE; ptr <= '0; cnt <= '0; hc <= '0; bits <= '0;
      cfg <= '0; cur_tag <= '0; prev_tag <= '0; first <= 1'b0; flush <= 1'b0;
      shout <= '0; rx <= '0; sck <= 1'b0; cs_conv <= 1'b0;
      res_valid <= 1'b0; res_data <= '0; res_chan <= '0; res_diff <= 1'b0; res_stale <= 1'b0;
    end else begin
      case (st)
        IDLE: if (start) begin
          ptr <= '0; first <= 1'b1; flush <= 1'b0; prev_tag <= '0; st <= PICK;
        end
        PICK: if (list_end) begin
          flush <= 1'b1; cnt <= '0; st <= ACQ;
        end else begin
          ptr <= ptr + 1'b1;
          if (!bad) begin
            cfg     <= {!ent[3], ent[0], ent[2], ent[1], use_com && !ent[3], unipolar, 1'b0};
            cur_tag <= ent;
            cnt     <= '0;
            st      <= ACQ;
          end
        end
        ACQ: if (cnt == ACQ_LAST) begin
          cnt <= '0; cs_conv <= 1'b1; st <= CONV;
        end else cnt <= cnt + 1'b1;
        CONV: if (cnt == CONV_LAST) begin
          cs_conv <= 1'b0;
          shout   <= {cfg, {(RES_W-CFG_W){1'b0}}};
          hc      <= '0;
          bits    <= '0;
          st      <= XFER;
        end else cnt <= cnt + 1'b1;
        XFER: if (!hc_done) hc <= hc + 1'b1;
        else begin
          hc <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[RES_W-2:0], sdo};
          end else begin
            sck   <= 1'b0;
            shout <= shout << 1;
            if (bits == BW'(RES_W - 1)) begin
              res_valid <= 1'b1;
              res_data  <= rx;
              res_chan  <= prev_tag[2:0];
              res_diff  <= prev_tag[3];
              res_stale <= first;
              first     <= 1'b0;
              prev_tag  <= cur_tag;
              st        <= POST;
            end else bits <= bits + 1'b1;
          end
        end
        POST: if (res_ready) begin
          res_valid <= 1'b0;
          st <= flush ? IDLE : PICK;
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [CW:0] hi_cnt, lo_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0; lo_cnt <= '0;
    end else begin
      hi_cnt <= !cs_conv ? '0 : ((&hi_cnt) ? hi_cnt : hi_cnt + 1'b1);
      lo_cnt <= sck ? '0 : ((&lo_cnt) ? lo_cnt : lo_cnt + 1'b1);
    end
  end

  assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    cs_conv |-> (!sck && !sdi));
  assert_conv_time_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_conv) |-> hi_cnt >= (CW+1)'(CONV_CYC));
  assert_acq_time_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_conv) |-> lo_cnt >= (CW+1)'(ACQ_CYC));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)
                                   && $stable(res_diff) && $stable(res_stale)));
  assert_no_conv_stall_R9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !cs_conv);
endmodule

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
  localparam int CONV = 20;
  localparam int ACQ  = 10;

  logic clk = 0, rst = 1, start = 0;
  logic [31:0] scan_list = '0;
  logic [3:0]  scan_len = '0;
  logic use_com = 0, unipolar = 0;
  logic [3:0] sck_half = 4'd2;
  logic sck, sdi, cs_conv, res_valid, res_ready = 1;
  logic [15:0] res_data;
  logic [2:0] res_chan;
  logic res_diff, res_stale;
  logic [15:0] sh = '0;
  wire sdo = sh[15];

  adc_scan_ctrl #(.ENTRIES(8), .CONV_CYC(CONV), .ACQ_CYC(ACQ), .DIVW(4), .RES_W(16)) dut (
    .clk(clk), .rst(rst), .start(start), .scan_list(scan_list), .scan_len(scan_len),
    .use_com(use_com), .unipolar(unipolar), .sck_half(sck_half), .sdo(sdo),
    .sck(sck), .sdi(sdi), .cs_conv(cs_conv), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_chan(res_chan), .res_diff(res_diff), .res_stale(res_stale));

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // converter model: setup word latched at convert strobe, echoed in next frame
  logic l_cs = 0, l_sck = 0;
  logic [15:0] cap = '0, m_res = 16'hFFFF;
  int rises = 0, frames = 0;
  always @(cs_conv or sck) begin
    if (cs_conv !== l_cs) begin
      if (cs_conv) begin
        if (frames > 0) begin
          chk(rises == 16, "R6 pulses", rises, 16);
          chk(cap[8:0] == 9'd0, "R2 pad", cap[8:0], 0);
        end
        m_res = {9'h1A5, cap[15:9]};
      end else begin
        sh = m_res;
        rises = 0;
        frames++;
      end
      l_cs = cs_conv;
    end
    if (sck !== l_sck) begin
      if (sck) begin
        cap = {cap[14:0], sdi};
        rises++;
      end else sh = sh << 1;
      l_sck = sck;
    end
  end

  int hi_c = 0, q_c = 0, sh_c = 0;
  logic p_cs = 0, p_sck = 0;
  always @(negedge clk) if (!rst) begin
    if (cs_conv) begin
      hi_c++;
      if (sck || sdi) chk(0, "R4 quiet", {sck, sdi}, 0);
      if (!p_cs) chk(q_c >= ACQ, "R5", q_c, ACQ);
    end else begin
      if (p_cs) chk(hi_c >= CONV, "R4 hold", hi_c, CONV);
      hi_c = 0;
    end
    if (sck) begin sh_c++; q_c = 0; end
    else begin
      if (p_sck) chk(sh_c == int'(sck_half), "R6 width", sh_c, sck_half);
      sh_c = 0;
      q_c++;
    end
    p_cs = cs_conv; p_sck = sck;
  end

  logic [15:0] b_data [16];
  logic [2:0]  b_chan [16];
  logic        b_diff [16];
  logic        b_stale[16];
  int beat_n = 0;
  always @(negedge clk) if (!rst && res_valid && res_ready) begin
    if (beat_n < 16) begin
      b_data[beat_n] = res_data; b_chan[beat_n] = res_chan;
      b_diff[beat_n] = res_diff; b_stale[beat_n] = res_stale;
    end
    beat_n++;
  end

  task automatic pulse_start();
    beat_n = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_beats(input int n);
    for (int i = 0; i < 20000 && beat_n < n; i++) @(negedge clk);
    repeat (300) @(negedge clk);
  endtask

  // {diff, chan[2:0], use_com, unipolar, expected setup word[6:0]}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 3'd0, 1'b0, 1'b1, 7'b1000010},
    {1'b0, 3'd5, 1'b0, 1'b0, 7'b1110000},
    {1'b0, 3'd6, 1'b1, 1'b1, 7'b1011110},
    {1'b0, 3'd7, 1'b0, 1'b1, 7'b1111010},
    {1'b1, 3'd0, 1'b0, 1'b1, 7'b0000010},
    {1'b1, 3'd3, 1'b0, 1'b0, 7'b0101000},
    {1'b1, 3'd4, 1'b1, 1'b1, 7'b0010010},
    {1'b1, 3'd7, 1'b1, 1'b0, 7'b0111000}
  };

  initial begin
    logic [15:0] d0;
    repeat (3) @(negedge clk);
    chk({cs_conv, sck, sdi, res_valid} == 4'b0, "R1 in reset", {cs_conv, sck, sdi, res_valid}, 0);
    rst = 0;
    repeat (40) @(negedge clk);
    chk({cs_conv, sck, sdi, res_valid} == 4'b0, "R1 idle", {cs_conv, sck, sdi, res_valid}, 0);

    foreach (VEC[i]) begin
      scan_list = '0;
      scan_list[3:0] = VEC[i][12:9];
      scan_len = 4'd1;
      use_com = VEC[i][8];
      unipolar = VEC[i][7];
      pulse_start();
      wait_beats(2);
      chk(beat_n == 2, "R10 count", beat_n, 2);
      chk(b_stale[0] == 1'b1 && b_chan[0] == 3'd0 && b_diff[0] == 1'b0, "R7 stale", {b_stale[0], b_diff[0], b_chan[0]}, 5'b10000);
      chk(b_stale[1] == 1'b0, "R7 fresh", b_stale[1], 0);
      chk(b_chan[1] == VEC[i][11:9] && b_diff[1] == VEC[i][12], "R7 tag", {b_diff[1], b_chan[1]}, VEC[i][12:9]);
      chk(b_data[1] == {9'h1A5, VEC[i][6:0]}, VEC[i][12] ? "R3 word" : "R2 word", b_data[1], {9'h1A5, VEC[i][6:0]});
      chk({cs_conv, sck, res_valid} == 3'b0, "R1 after scan", {cs_conv, sck, res_valid}, 0);
    end

    // directed: skipped channel-7 entry under common mode, stalled stream, slower SCK
    sck_half = 4'd3;
    scan_list = '0;
    scan_list[15:0] = 16'h3A71;
    scan_len = 4'd4;
    use_com = 1; unipolar = 0;
    res_ready = 0;
    pulse_start();
    for (int i = 0; i < 5000 && !res_valid; i++) @(negedge clk);
    d0 = res_data;
    chk(res_valid && res_stale, "R7 first stale", {res_valid, res_stale}, 2'b11);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk(res_valid && res_data == d0 && !cs_conv, "R9 stall", {res_valid, cs_conv, res_data}, {2'b10, d0});
    end
    res_ready = 1;
    wait_beats(4);
    chk(beat_n == 4, "R8 R10 count", beat_n, 4);
    chk(b_stale[0] && !b_stale[1], "R7 stale order", {b_stale[0], b_stale[1]}, 2'b10);
    chk(b_chan[1] == 3'd1 && !b_diff[1] && b_data[1] == {9'h1A5, 7'b1100100}, "R8 beat1", b_data[1], {9'h1A5, 7'b1100100});
    chk(b_chan[2] == 3'd2 && b_diff[2] && b_data[2] == {9'h1A5, 7'b0001000}, "R8 beat2", b_data[2], {9'h1A5, 7'b0001000});
    chk(b_chan[3] == 3'd3 && !b_diff[3] && b_data[3] == {9'h1A5, 7'b1101100}, "R8 beat3", b_data[3], {9'h1A5, 7'b1101100});
    chk({cs_conv, sck, res_valid} == 3'b0, "R1 final idle", {cs_conv, sck, res_valid}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule